// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block is one registered stage of an address-generation pipeline. Each request supplies a mode code, a base register value, an index register value, a two-bit scale code and a displacement. The block forms a 32-bit memory address from them and presents it, with a one-cycle valid pulse, on the clock edge after the request.

The displacement arrives either as a full 32-bit signed value or as a short signed byte. In the short case, only the low byte of the displacement input is used, and it is sign-extended. The scale code multiplies the index by 1, 2, 4 or 8 through a left shift. Every mode uses a single three-operand sum: operands that a mode leaves out are forced to zero, and the result wraps modulo 2^32.

Register-file reads, instruction decoding, segmentation and the memory access itself happen elsewhere.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low, `addr_out` is 0 and `addr_vld` is 0.
- R2: `addr_vld` is 1 in exactly the cycle after a clock edge that samples `req` high, and 0 after an edge that samples `req` low.
- R3: `addr_out` keeps its value across every edge that samples `req` low.
- R4: Mode code 0 (direct) gives the displacement alone as the address.
- R5: Mode code 1 (register indirect) gives the base alone as the address.
- R6: Mode code 2 gives base plus displacement.
- R7: Mode code 3 gives the scaled index plus displacement, with no base.
- R8: Mode code 4 gives base plus scaled index, with no displacement.
- R9: Mode code 5 gives base plus scaled index plus displacement. For example, base 1000, index 40, scale code 2 and displacement 200 give 1360.
- R10: Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8 respectively.
- R11: With `disp_wide` = 0, only `disp[7:0]` is used. It is sign-extended to 32 bits, and `disp[31:8]` has no effect. With `disp_wide` = 1, all 32 bits of `disp` are used.
- R12: The sum wraps modulo 2^32, and no fault is indicated.
- R13: Mode codes 6 and 7 behave as mode code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe; operands are sampled on the edge where it is high |
| mode | input | 3 | Addressing mode code (0 to 7) |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index scale code |
| disp_wide | input | 1 | 1: 32-bit displacement; 0: sign-extended byte displacement |
| disp | input | 32 | Displacement |
| addr_out | output | 32 | Registered effective address |
| addr_vld | output | 1 | One-cycle valid pulse for `addr_out` |

## Verification
The embedded assertions check the following on every cycle:
- the valid pulse follows each request by exactly one edge;
- the address holds between requests;
- direct and register-indirect modes pass their single operand through;
- a short displacement in direct mode fills the upper 24 bits with its sign.

The arithmetic forms cannot be checked by those properties. They are shown only by the bench's scenarios, which compute the expected sums independently:
- every scale code;
- negative short displacements with junk in the upper bits;
- wrap-around at 2^32;
- the two spare mode codes.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 32,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [1:0]    scale_code,
  input  logic          disp_wide,
  input  logic [AW-1:0] disp,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld
);

  localparam int EXT = AW - SW;

  localparam logic [2:0] M_DIRECT   = 3'd0;
  localparam logic [2:0] M_REG_IND  = 3'd1;
  localparam logic [2:0] M_BASE_D   = 3'd2;
  localparam logic [2:0] M_IDX_D    = 3'd3;
  localparam logic [2:0] M_BASE_IDX = 3'd4;

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] idx_scaled;
  logic          use_base, use_idx, use_disp;
  logic [AW-1:0] op_base, op_idx, op_disp;
  logic [AW-1:0] ea_next;

  assign disp_ext   = disp_wide ? disp : {{EXT{disp[SW-1]}}, disp[SW-1:0]};
  assign idx_scaled = index_val << scale_code;

  assign use_base = (mode != M_DIRECT) && (mode != M_IDX_D);
  assign use_idx  = (mode >= M_IDX_D);
  assign use_disp = (mode != M_REG_IND) && (mode != M_BASE_IDX);

  assign op_base = use_base ? base_val   : '0;
  assign op_idx  = use_idx  ? idx_scaled : '0;
  assign op_disp = use_disp ? disp_ext   : '0;

  assign ea_next = op_base + op_idx + op_disp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_vld <= req;
      if (req) addr_out <= ea_next;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (addr_out == '0 && !addr_vld));

  a_r2_vld_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> addr_vld);

  a_r2_vld_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !addr_vld);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(addr_out));

  a_r4_direct_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == M_DIRECT && disp_wide) |=> addr_out == $past(disp));

  a_r5_reg_indirect: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == M_REG_IND) |=> addr_out == $past(base_val));

  a_r11_short_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == M_DIRECT && !disp_wide) |=>
      (addr_out[AW-1:SW] == {EXT{$past(disp[SW-1])}} &&
       addr_out[SW-1:0] == $past(disp[SW-1:0])));

endmodule

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] base_val = '0, index_val = '0, disp = '0;
  logic [1:0]  scale_code = '0;
  logic        disp_wide = 1'b0;
  logic [31:0] addr_out;
  logic        addr_vld;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_exp = '0;

  always #5 clk = ~clk;

  ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
    .base_val(base_val), .index_val(index_val), .scale_code(scale_code),
    .disp_wide(disp_wide), .disp(disp),
    .addr_out(addr_out), .addr_vld(addr_vld)
  );

  function automatic logic [31:0] model(input logic [2:0] m, input logic [31:0] b,
                                        input logic [31:0] x, input logic [1:0] s,
                                        input logic w, input logic [31:0] d);
    logic [31:0] dx, xs;
    dx = w ? d : {{24{d[7]}}, d[7:0]};
    xs = x * (32'd1 << s);
    case (m)
      3'd0: return dx;
      3'd1: return b;
      3'd2: return b + dx;
      3'd3: return xs + dx;
      3'd4: return b + xs;
      default: return b + xs + dx;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [2:0] m, input logic [31:0] b,
                       input logic [31:0] x, input logic [1:0] s,
                       input logic w, input logic [31:0] d);
    @(negedge clk);
    mode = m; base_val = b; index_val = x; scale_code = s; disp_wide = w; disp = d;
    req = 1'b1;
    last_exp = model(m, b, x, s, w, d);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0;
      mode = 3'd5; base_val = 32'hDEAD_BEEF; index_val = 32'h1234_5678;
      disp = 32'h0BAD_F00D;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && addr_vld) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual unexpected valid, expected no valid");
      end else begin
        check(tag_q.pop_front(), addr_out, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset addr", addr_out, 32'h0);
    check("R1 reset vld", {31'b0, addr_vld}, 32'h0);
    rst_n = 1'b1;
    idle(2);
    check("R2 idle vld low", {31'b0, addr_vld}, 32'h0);

    drive("R9 example 1360", 3'd5, 32'd1000, 32'd40, 2'd2, 1'b1, 32'd200);
    drive("R4 direct wide", 3'd0, 32'h1111_1111, 32'h2222_2222, 2'd3, 1'b1, 32'h8000_1234);
    drive("R5 reg indirect", 3'd1, 32'hCAFE_0000, 32'h99, 2'd1, 1'b1, 32'h55);
    drive("R6 base+disp", 3'd2, 32'h0000_4000, 32'hFFFF, 2'd3, 1'b1, 32'h0000_0123);
    drive("R7 idx+disp", 3'd3, 32'hFFFF_FFFF, 32'd100, 2'd3, 1'b1, 32'd7);
    drive("R8 base+idx", 3'd4, 32'd500, 32'd3, 2'd1, 1'b1, 32'hFFFF_0000);
    for (int s = 0; s < 4; s++)
      drive("R10 scale", 3'd4, 32'd0, 32'd5, s[1:0], 1'b1, 32'd0);
    drive("R11 short neg direct", 3'd0, 32'd0, 32'd0, 2'd0, 1'b0, 32'h1234_56F0);
    drive("R11 short pos direct", 3'd0, 32'd0, 32'd0, 2'd0, 1'b0, 32'hFFFF_FF7F);
    drive("R11 short neg full", 3'd5, 32'd1000, 32'd2, 2'd3, 1'b0, 32'hABCD_EF80);
    drive("R12 wrap", 3'd5, 32'hFFFF_FFF0, 32'h4000_0000, 2'd2, 1'b1, 32'h20);
    drive("R13 mode6", 3'd6, 32'd10, 32'd3, 2'd2, 1'b1, 32'd100);
    drive("R13 mode7", 3'd7, 32'd20, 32'd1, 2'd3, 1'b0, 32'h0000_00FE);
    idle(1);
    @(negedge clk);
    check("R3 hold addr", addr_out, last_exp);
    check("R2 vld drops", {31'b0, addr_vld}, 32'h0);
    idle(4);
    check("R3 hold after idle", addr_out, last_exp);
    check("R2 queue drained", exp_q.size(), 0);

    drive("R9 full again", 3'd5, 32'h100, 32'h10, 2'd0, 1'b1, 32'h1);
    idle(3);
    check("R2 queue drained 2", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule